// File: doc/BRIEF.md
# Unsigned Integer to Single-Precision Converter with Vector Merge

This block turns an unsigned integer of 32 or 64 bits into an IEEE-754 single-precision value. The result goes into the low lane of a 128-bit vector result, and the other three lanes are taken unchanged from a pass-through vector source. A separate output carries the extension bits of the widest vector register above bit 127. These bits are always cleared.

The width of the operand depends on two inputs together: a 64-bit-mode flag and a width select. The rounding mode is chosen for each operation. An embedded override field is used only when the operand came from a register and the override is enabled. In every other case the global rounding field is used. A conversion that discards nonzero bits raises the inexact flag.

The datapath has three parts: mode and operand selection, a leading-zero normaliser, and a rounder. One output register stage follows them, so a result appears one clock after its operation is presented.

Top module: `uint_fp32_merge`

## Requirements
- R1: With rounding code 00 (nearest, ties to even), the low 32 bits of the result are the correctly rounded single-precision value of the unsigned operand.
- R2: When both `mode64` and `wide_sel` are 1, all 64 bits of `src_int` are converted. Otherwise only `src_int[31:0]` is converted, and `src_int[63:32]` has no effect.
- R3: When `mode64` is 0, `wide_sel` has no effect on the result or on the inexact flag.
- R4: The mode code is `rc_ovr` when `src_is_reg` and `rc_ovr_en` are both 1, and `rc_glb` otherwise. The codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. Codes 01 and 11 both truncate.
- R5: `result[127:32]` equals `pass_vec[127:32]` of the same operation.
- R6: `result_ext` is all zeros at all times.
- R7: `inexact` is 1 exactly when nonzero bits were discarded. An operand below 2^24 never sets it.
- R8: The sign bit `result[31]` is always 0.
- R9: A zero operand gives +0.0 (`result[31:0]` = 0x00000000) with `inexact` = 0.
- R10: The result never becomes infinity. The operand 2^64-1 gives 0x5F800000 under codes 00 and 10, and 0x5F7FFFFF under codes 01 and 11.
- R11: `out_valid`, `result` and `inexact` update one clock after `in_valid` is 1. `out_valid` is 0 in the cycle after `in_valid` is 0. Reset clears `out_valid`, `result` and `inexact`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| src_int | input | 64 | Unsigned integer operand |
| src_is_reg | input | 1 | Operand came from a register |
| pass_vec | input | 128 | Vector source for lanes above bit 31 |
| mode64 | input | 1 | 64-bit mode active |
| wide_sel | input | 1 | Requests a 64-bit operand |
| rc_ovr_en | input | 1 | Embedded rounding override enable |
| rc_ovr | input | 2 | Embedded rounding code |
| rc_glb | input | 2 | Global rounding code |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Merged vector result |
| result_ext | output | 384 | Destination bits above 127, always zero |
| inexact | output | 1 | Precision flag |

## Verification
The clocked assertions assume `rst_n` is held low long enough for the output register to clear. They also assume every input is driven to a known value whenever `in_valid` is high. The stimulus changes inputs only on the falling clock edge and keeps `in_valid` high during every operation, so each rising edge captures a stable operation.

The bench draws operands over a spread of magnitudes, from a few bits up to the full 64. It also varies `mode64`, `wide_sel`, the source flag, the override enable and both rounding codes. This covers every branch of the width and mode selection, including the cases where the upper half or the override must be ignored.

// File: rtl/fp32cvt_pkg.sv
package fp32cvt_pkg;
  localparam int INT_W  = 64;
  localparam int NARROW = 32;
  localparam int MANT_W = 24;
  localparam int FRAC_W = MANT_W - 1;
  localparam int EXP_W  = 8;
  localparam int BIAS   = 127;
  localparam int LZ_W   = $clog2(INT_W) + 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [INT_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            seen;
    n    = '0;
    seen = 1'b0;
    for (int i = INT_W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  function automatic logic want_increment(input rmode_e rm, input logic lsb,
                                          input logic g, input logic s);
    logic inc;
    case (rm)
      RM_NEAR: inc = g & (s | lsb);
      RM_UP:   inc = g | s;
      default: inc = 1'b0;
    endcase
    return inc;
  endfunction
endpackage

// File: rtl/cvt_mode_sel.sv
module cvt_mode_sel
  import fp32cvt_pkg::*;
(
  input  logic [INT_W-1:0] src_int,
  input  logic             mode64,
  input  logic             wide_sel,
  input  logic             src_is_reg,
  input  logic             rc_ovr_en,
  input  logic [1:0]       rc_ovr,
  input  logic [1:0]       rc_glb,
  output logic [INT_W-1:0] operand,
  output logic             wide,
  output rmode_e           rm
);
  logic use_ovr;

  assign wide    = mode64 & wide_sel;
  assign use_ovr = src_is_reg & rc_ovr_en;
  assign operand = wide ? src_int : {{(INT_W-NARROW){1'b0}}, src_int[NARROW-1:0]};
  assign rm      = rmode_e'(use_ovr ? rc_ovr : rc_glb);
endmodule

// File: rtl/cvt_normalize.sv
module cvt_normalize
  import fp32cvt_pkg::*;
(
  input  logic [INT_W-1:0]  operand,
  input  logic              wide,
  output logic              is_zero,
  output logic [LZ_W-1:0]   lz,
  output logic [MANT_W-1:0] mant,
  output logic              guard,
  output logic              sticky
);
  logic [INT_W-1:0] norm;

  assign is_zero = (operand == '0);
  assign lz      = lead_zeros(operand);
  assign norm    = operand << lz;
  assign mant    = norm[INT_W-1 -: MANT_W];
  assign guard   = norm[INT_W-MANT_W-1];
  assign sticky  = |norm[INT_W-MANT_W-2:0];

  // R3 / R2: a narrow operand must leave the upper half empty after selection
  always_comb begin
    if (!wide && !is_zero) begin
      a_r2_narrow_lz: assert (lz >= LZ_W'(INT_W - NARROW));
    end
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import fp32cvt_pkg::*;
(
  input  logic              is_zero,
  input  logic [LZ_W-1:0]   lz,
  input  logic [MANT_W-1:0] mant,
  input  logic              guard,
  input  logic              sticky,
  input  rmode_e            rm,
  output logic [31:0]       fp32,
  output logic              inexact
);
  logic              inc;
  logic [MANT_W:0]   sum;
  logic              carry;
  logic [9:0]        exp_full;
  logic [FRAC_W-1:0] frac;

  assign inc      = want_increment(rm, mant[0], guard, sticky);
  assign sum      = {1'b0, mant} + {{MANT_W{1'b0}}, inc};
  assign carry    = sum[MANT_W];
  assign exp_full = 10'(BIAS + INT_W - 1) - 10'(lz) + 10'(carry);
  assign frac     = carry ? '0 : sum[FRAC_W-1:0];
  assign inexact  = !is_zero & (guard | sticky);
  assign fp32     = is_zero ? 32'h0 : {1'b0, exp_full[EXP_W-1:0], frac};

  // R10: exponent field never saturates to the infinity encoding
  always_comb begin
    if (!is_zero) begin
      a_r10_no_overflow: assert (exp_full < 10'd255);
    end
  end
endmodule

// File: rtl/uint_fp32_merge.sv
module uint_fp32_merge
  import fp32cvt_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int MAX_VL = 512,
  localparam int EXT_W = MAX_VL - VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       src_int,
  input  logic              src_is_reg,
  input  logic [VEC_W-1:0]  pass_vec,
  input  logic              mode64,
  input  logic              wide_sel,
  input  logic              rc_ovr_en,
  input  logic [1:0]        rc_ovr,
  input  logic [1:0]        rc_glb,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result,
  output logic [EXT_W-1:0]  result_ext,
  output logic              inexact
);
  logic [INT_W-1:0]  operand;
  logic              wide;
  rmode_e            rm;
  logic              op_zero;
  logic [LZ_W-1:0]   lz;
  logic [MANT_W-1:0] mant;
  logic              guard;
  logic              sticky;
  logic [31:0]       fp32;
  logic              ix_comb;

  cvt_mode_sel u_sel (
    .src_int(src_int), .mode64(mode64), .wide_sel(wide_sel),
    .src_is_reg(src_is_reg), .rc_ovr_en(rc_ovr_en), .rc_ovr(rc_ovr),
    .rc_glb(rc_glb), .operand(operand), .wide(wide), .rm(rm)
  );

  cvt_normalize u_norm (
    .operand(operand), .wide(wide), .is_zero(op_zero), .lz(lz),
    .mant(mant), .guard(guard), .sticky(sticky)
  );

  cvt_round u_rnd (
    .is_zero(op_zero), .lz(lz), .mant(mant), .guard(guard),
    .sticky(sticky), .rm(rm), .fp32(fp32), .inexact(ix_comb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= {pass_vec[VEC_W-1:32], fp32};
        inexact <= ix_comb;
      end
    end
  end

  assign result_ext = '0;

  a_r5_merge: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> result[VEC_W-1:32] == $past(pass_vec[VEC_W-1:32]));

  a_r8_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !result[31]);

  a_r9_zero_plus: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_zero) |=> (result[31:0] == 32'h0) && !inexact);

  a_r7_small_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (operand >> MANT_W) == '0) |=> !inexact);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));
endmodule

// File: tb/uint_fp32_merge_tb.sv
module uint_fp32_merge_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [63:0]  src_int = '0;
  logic         src_is_reg = 1'b0;
  logic [127:0] pass_vec = '0;
  logic         mode64 = 1'b0;
  logic         wide_sel = 1'b0;
  logic         rc_ovr_en = 1'b0;
  logic [1:0]   rc_ovr = '0;
  logic [1:0]   rc_glb = '0;
  logic         out_valid;
  logic [127:0] result;
  logic [383:0] result_ext;
  logic         inexact;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  uint_fp32_merge u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_int(src_int),
    .src_is_reg(src_is_reg), .pass_vec(pass_vec), .mode64(mode64),
    .wide_sel(wide_sel), .rc_ovr_en(rc_ovr_en), .rc_ovr(rc_ovr),
    .rc_glb(rc_glb), .out_valid(out_valid), .result(result),
    .result_ext(result_ext), .inexact(inexact)
  );

  // bench model: {inexact, fp32} for an operand and a mode code
  function automatic logic [32:0] ref_cvt(logic [63:0] v, logic [1:0] code);
    int          p;
    int          sh;
    logic [63:0] m, rem, half;
    logic        up;
    logic [7:0]  e;
    if (v == 64'd0) return 33'd0;
    p = 63;
    while (!v[p]) p--;
    up  = 1'b0;
    rem = 64'd0;
    if (p <= 23) begin
      m = v << (23 - p);
    end else begin
      sh   = p - 23;
      m    = v >> sh;
      rem  = v - (m << sh);
      half = 64'd1 << (sh - 1);
      if (code == 2'b00) up = (rem > half) || (rem == half && m[0]);
      else if (code == 2'b10) up = (rem != 64'd0);
    end
    m = m + {63'd0, up};
    e = 8'(127 + p);
    if (m[24]) begin
      m = m >> 1;
      e = e + 8'd1;
    end
    return {rem != 64'd0, 1'b0, e, m[22:0]};
  endfunction

  task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [63:0] x, logic isreg, logic [127:0] pv,
                        logic m64, logic ws, logic oen, logic [1:0] orc, logic [1:0] grc);
    logic [63:0] opnd;
    logic [1:0]  code;
    logic [32:0] r;
    @(negedge clk);
    src_int = x; src_is_reg = isreg; pass_vec = pv; mode64 = m64;
    wide_sel = ws; rc_ovr_en = oen; rc_ovr = orc; rc_glb = grc;
    in_valid = 1'b1;
    opnd = (m64 && ws) ? x : {32'd0, x[31:0]};
    code = (isreg && oen) ? orc : grc;
    r    = ref_cvt(opnd, code);
    @(negedge clk);
    check(tag, "value", {96'd0, result[31:0]}, {96'd0, r[31:0]});
    check(tag, "inexact", {127'd0, inexact}, {127'd0, r[32]});
    check("R5", "merge", {32'd0, result[127:32]}, {32'd0, pv[127:32]});
    check("R6", "ext", {127'd0, |result_ext}, 128'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] pv;
    pv = {$urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    check("R11", "reset valid", {127'd0, out_valid}, 128'd0);
    check("R11", "reset result", result, 128'd0);
    check("R11", "reset inexact", {127'd0, inexact}, 128'd0);
    rst_n = 1'b1;

    // directed corners
    run_op("R9", 64'd0, 1'b1, pv, 1'b1, 1'b1, 1'b1, 2'b10, 2'b10);
    check("R9", "zero bits", {96'd0, result[31:0]}, 128'd0);
    run_op("R1", 64'd1, 1'b0, pv, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    check("R1", "one", {96'd0, result[31:0]}, {96'd0, 32'h3F800000});
    run_op("R7", 64'h00FF_FFFF, 1'b0, pv, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    check("R7", "exact 2^24-1", {127'd0, inexact}, 128'd0);
    for (int c = 0; c < 4; c++) begin
      run_op("R4", 64'h0100_0001, 1'b0, pv, 1'b0, 1'b0, 1'b0, 2'b00, 2'(c));
      run_op("R4", 64'h0100_0003, 1'b1, pv, 1'b0, 1'b0, 1'b1, 2'(c), 2'(3 - c));
      run_op("R4", 64'h0100_0003, 1'b0, pv, 1'b0, 1'b0, 1'b1, 2'(c), 2'(3 - c));
      run_op("R10", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, pv, 1'b1, 1'b1, 1'b0, 2'b00, 2'(c));
      check("R10", "max64", {96'd0, result[31:0]},
            {96'd0, (c == 0 || c == 2) ? 32'h5F800000 : 32'h5F7FFFFF});
    end
    run_op("R2", 64'hDEAD_BEEF_0000_0005, 1'b0, pv, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);
    check("R2", "upper ignored", {96'd0, result[31:0]}, {96'd0, 32'h40A00000});
    run_op("R3", 64'hDEAD_BEEF_0000_0005, 1'b0, pv, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00);
    check("R3", "wide_sel ignored", {96'd0, result[31:0]}, {96'd0, 32'h40A00000});
    run_op("R2", 64'h0000_0001_0000_0000, 1'b0, pv, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00);
    check("R2", "2^32", {96'd0, result[31:0]}, {96'd0, 32'h4F800000});
    run_op("R1", 64'h0000_0000_0100_0001, 1'b0, pv, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    check("R1", "tie to even", {96'd0, result[31:0]}, {96'd0, 32'h4B800000});

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R11", "idle valid", {127'd0, out_valid}, 128'd0);

    // random mix over magnitudes
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] x;
      x  = {$urandom, $urandom} >> ($urandom % 64);
      pv = {$urandom, $urandom, $urandom, $urandom};
      run_op((i % 2 == 0) ? "R1" : "R4", x, 1'($urandom), pv, 1'($urandom),
             1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
      check("R8", "sign", {127'd0, result[31]}, 128'd0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end
endmodule